// File: doc/BRIEF.md
# Byte-Command SPI Host Bridge

This block sits between a host byte channel and an SPI master port. The host sends a stream of command bytes over a valid/ready channel, and the block sends a reply byte for each one on a second valid/ready channel. Most commands are a single byte with the opcode and its argument packed together. These commands set the chip-select level, the serial clock rate, the clock polarity, phase and sample point, and a small group of peripheral control outputs. Each of them is acknowledged with 0x01.

Data moves in two ways. A bulk command carries its byte count in its low nibble and is followed by that many data bytes. A pair of nibble commands builds a byte in two parts: the high half is kept, and each low-half command sends a byte at once. Every byte shifted out on MOSI returns the byte captured on MISO during the same transfer. The pad tri-state is not modelled in the block. It is brought out as a single drive-enable flag.

Top module: `spi_cmd_bridge`

## Requirements
- R1: After reset the outputs are as follows. `spi_cs` is 1, `spi_sclk` is 0, `pin_drive`, `pwr_en`, `pullup_en`, `aux_out` and `exit_pulse` are all 0, `in_ready` is 1 and `out_valid` is 0. The rate code is 0 and the bus setting is drive=0, polarity=0, phase=1, sample=0.
- R2: Opcode 0x02 sets `spi_cs` to 0 and opcode 0x03 sets it to 1. Each replies 0x01. `spi_cs` does not change while a byte is shifting.
- R3: Opcode 0x10+n (n = 0..15) replies 0x01 and then accepts n+1 data bytes. The block shifts out each data byte MSB first and replies with the byte it sampled on `spi_miso` before it accepts the next data byte.
- R4: Opcode 0x60+c (c = 0..7) replies 0x01 and selects rates of 30 kHz, 125 kHz, 250 kHz, 1 MHz, 2 MHz, 2.6 MHz, 4 MHz and 8 MHz for codes 0 through 7. The SCLK half period is floor(CLK_HZ / (2·f)) clock cycles, and never less than 1.
- R5: Opcode 0x80 + 8w + 4x + 2y + z replies 0x01. Bit w drives `pin_drive`. Bit x is the idle level of `spi_sclk`, and `spi_sclk` moves only while a byte is shifting. Bit y=1 changes data on the active-to-idle edge and y=0 changes it on the idle-to-active edge. Bit z=0 samples mid-bit and z=1 samples at the end of the bit. The round trip is lossless in all 16 settings.
- R6: Opcode 0x40 + 8w + 4x + 2y + z replies 0x01 and sets `pwr_en`=w, `pullup_en`=x, `aux_out`=y and `spi_cs`=z. It leaves `pin_drive` unchanged.
- R7: Opcode 0x30+h stores h as the high nibble and replies 0x01. Opcode 0x20+l shifts out {h, l} at once and replies with the byte read. The stored nibble is kept for later 0x2l commands and is 0 after reset.
- R8: Opcode 0x01 replies with the four bytes 0x53, 0x50, 0x49, 0x31 in that order.
- R9: Opcode 0x00 raises `exit_pulse` for exactly one cycle and produces no reply.
- R10: Every other opcode (0x04–0x0F, 0x50–0x5F, 0x68–0x7F, 0x90–0xFF) replies 0x00 and changes no output.
- R11: `in_ready` is 0 while a byte is shifting and while a reply is waiting to be taken.
- R12: While `out_valid` is 1 and `out_ready` is 0, the reply stays valid and `out_data` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Host byte is valid |
| in_data | input | 8 | Host command or data byte |
| in_ready | output | 1 | Block can accept a host byte |
| out_valid | output | 1 | Reply byte is valid |
| out_data | output | 8 | Reply byte |
| out_ready | input | 1 | Host takes the reply |
| exit_pulse | output | 1 | One-cycle request to leave this mode |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs | output | 1 | Chip-select level |
| pin_drive | output | 1 | 1 = push-pull drive for SCLK/MOSI/CS, 0 = high impedance |
| pwr_en | output | 1 | Power supply enable |
| pullup_en | output | 1 | Pull-up enable |
| aux_out | output | 1 | Auxiliary output, always driven |

## Verification
The assertions assume the host never changes the bus setting or the chip select while a byte is shifting. The block itself enforces this by holding `in_ready` low. The SCLK-quiet property also assumes the polarity bit stays put across the cycle it compares. The bench changes polarity only through a bus-setting command sent with chip select high. Its SPI slave model drives MISO a short delay after each SCLK edge, as a real device would. It also acts only while chip select is low, so idle-level changes from reconfiguration never look like clock edges to it.

// File: rtl/spi_cmd_pkg.sv
`timescale 1ns/1ps
package spi_cmd_pkg;

  typedef struct packed {
    logic drive;
    logic cpol;
    logic cke;
    logic smp;
  } bus_cfg_t;

  typedef enum logic [1:0] {
    ST_CMD,
    ST_VER,
    ST_BULK,
    ST_XFER
  } dec_state_t;

  localparam bus_cfg_t BUS_CFG_RESET = 4'b0010;

  function automatic int unsigned rate_hz(input int unsigned code);
    case (code)
      0:       return 30_000;
      1:       return 125_000;
      2:       return 250_000;
      3:       return 1_000_000;
      4:       return 2_000_000;
      5:       return 2_600_000;
      6:       return 4_000_000;
      default: return 8_000_000;
    endcase
  endfunction

  function automatic logic [7:0] ver_char(input logic [1:0] idx);
    case (idx)
      2'd0:    return 8'h53;
      2'd1:    return 8'h50;
      2'd2:    return 8'h49;
      default: return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/spi_rate_sel.sv
`timescale 1ns/1ps
module spi_rate_sel #(
  parameter int unsigned CLK_HZ = 64_000_000,
  parameter int unsigned HW     = 12
) (
  input  logic [2:0]    code,
  output logic [HW-1:0] half
);
  import spi_cmd_pkg::*;

  logic [HW-1:0] tbl [8];

  for (genvar g = 0; g < 8; g++) begin : g_rate
    localparam int unsigned RAW  = CLK_HZ / (2 * rate_hz(g));
    localparam int unsigned HC   = (RAW < 1) ? 1 : RAW;
    assign tbl[g] = HW'(HC);
  end

  assign half = tbl[code];
endmodule

// File: rtl/spi_shift_engine.sv
`timescale 1ns/1ps
module spi_shift_engine #(
  parameter int unsigned HW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [7:0]    tx_byte,
  input  logic          cpol,
  input  logic          cke,
  input  logic          smp,
  input  logic [HW-1:0] half,
  input  logic          miso,
  output logic          sclk,
  output logic          mosi,
  output logic          busy,
  output logic          done,
  output logic [7:0]    rx_byte
);
  localparam logic [4:0] LAST_EDGE = 5'd17;
  localparam logic [4:0] TOGGLES   = 5'd16;

  logic          busy_q, busy_d;
  logic          ph_q, ph_d;
  logic          mosi_q, mosi_d;
  logic          done_q, done_d;
  logic [HW-1:0] div_q, div_d;
  logic [4:0]    edge_q, edge_d;
  logic [7:0]    tx_q, tx_d;
  logic [7:0]    rx_q, rx_d;

  logic [4:0] n_next;
  logic [4:0] samp_off;
  logic [4:0] lnch_off;
  logic       sample_hit;
  logic       launch_hit;
  logic [HW-1:0] half_m1;

  assign n_next   = edge_q + 5'd1;
  assign samp_off = {4'b0, ~cke} + {4'b0, smp};
  assign lnch_off = {4'b0, ~cke};
  assign half_m1  = half - {{(HW-1){1'b0}}, 1'b1};

  // sample edges: 1+off, 3+off, ... 15+off ; launch edges: 2+c .. 14+c
  assign sample_hit = (n_next >= 5'd1 + samp_off) && (n_next <= 5'd15 + samp_off) &&
                      (n_next[0] != samp_off[0]);
  assign launch_hit = (n_next >= 5'd2 + lnch_off) && (n_next <= 5'd14 + lnch_off) &&
                      (n_next[0] == lnch_off[0]);

  always_comb begin
    busy_d = busy_q;
    ph_d   = ph_q;
    mosi_d = mosi_q;
    done_d = 1'b0;
    div_d  = div_q;
    edge_d = edge_q;
    tx_d   = tx_q;
    rx_d   = rx_q;
    if (!busy_q) begin
      if (start) begin
        busy_d = 1'b1;
        div_d  = half_m1;
        edge_d = 5'd0;
        tx_d   = tx_byte;
        mosi_d = tx_byte[7];
        ph_d   = 1'b0;
      end
    end else if (div_q == '0) begin
      div_d  = half_m1;
      edge_d = n_next;
      if (n_next <= TOGGLES) ph_d = ~ph_q;
      if (sample_hit) rx_d = {rx_q[6:0], miso};
      if (launch_hit) begin
        tx_d   = {tx_q[6:0], 1'b0};
        mosi_d = tx_q[6];
      end
      if (n_next == LAST_EDGE) begin
        busy_d = 1'b0;
        done_d = 1'b1;
        ph_d   = 1'b0;
      end
    end else begin
      div_d = div_q - {{(HW-1){1'b0}}, 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ph_q   <= 1'b0;
      mosi_q <= 1'b0;
      done_q <= 1'b0;
      div_q  <= '0;
      edge_q <= 5'd0;
      tx_q   <= 8'h00;
      rx_q   <= 8'h00;
    end else begin
      busy_q <= busy_d;
      ph_q   <= ph_d;
      mosi_q <= mosi_d;
      done_q <= done_d;
      div_q  <= div_d;
      edge_q <= edge_d;
      tx_q   <= tx_d;
      rx_q   <= rx_d;
    end
  end

  assign sclk    = busy_q ? (cpol ^ ph_q) : cpol;
  assign mosi    = mosi_q;
  assign busy    = busy_q;
  assign done    = done_q;
  assign rx_byte = rx_q;
endmodule

// File: rtl/spi_cmd_decoder.sv
`timescale 1ns/1ps
module spi_cmd_decoder
  import spi_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  output logic       in_ready,
  output logic       out_valid,
  output logic [7:0] out_data,
  input  logic       out_ready,
  input  logic       eng_done,
  input  logic [7:0] eng_rx,
  output logic       eng_start,
  output logic [7:0] eng_tx,
  output logic       cs_level,
  output logic       pwr_en,
  output logic       pullup_en,
  output logic       aux_out,
  output logic [2:0] rate_code,
  output bus_cfg_t   bus_cfg,
  output logic       exit_pulse
);
  localparam logic [7:0] ACK  = 8'h01;
  localparam logic [7:0] NACK = 8'h00;

  dec_state_t st_q, st_d;
  logic       ov_q, ov_d;
  logic [7:0] od_q, od_d;
  logic [1:0] vi_q, vi_d;
  logic [3:0] left_q, left_d;
  logic       bulk_q, bulk_d;
  logic [3:0] hi_q, hi_d;
  logic       cs_q, cs_d;
  logic [2:0] per_q, per_d;
  logic [2:0] rc_q, rc_d;
  bus_cfg_t   cfg_q, cfg_d;
  logic       ex_q, ex_d;

  logic accept;

  assign in_ready = ((st_q == ST_CMD) || (st_q == ST_BULK)) && !ov_q;
  assign accept   = in_valid && in_ready;

  always_comb begin
    st_d      = st_q;
    ov_d      = ov_q;
    od_d      = od_q;
    vi_d      = vi_q;
    left_d    = left_q;
    bulk_d    = bulk_q;
    hi_d      = hi_q;
    cs_d      = cs_q;
    per_d     = per_q;
    rc_d      = rc_q;
    cfg_d     = cfg_q;
    ex_d      = 1'b0;
    eng_start = 1'b0;
    eng_tx    = in_data;

    if (ov_q && out_ready) begin
      if ((st_q == ST_VER) && (vi_q != 2'd3)) begin
        vi_d = vi_q + 2'd1;
        od_d = ver_char(vi_q + 2'd1);
      end else begin
        ov_d = 1'b0;
        if (st_q == ST_VER) st_d = ST_CMD;
      end
    end

    if (accept && (st_q == ST_BULK)) begin
      eng_start = 1'b1;
      st_d      = ST_XFER;
    end else if (accept) begin
      ov_d = 1'b1;
      od_d = ACK;
      casez (in_data)
        8'h00: begin
          ov_d = 1'b0;
          ex_d = 1'b1;
        end
        8'h01: begin
          od_d = ver_char(2'd0);
          vi_d = 2'd0;
          st_d = ST_VER;
        end
        8'b0000_001?: cs_d = in_data[0];
        8'b0001_????: begin
          left_d = in_data[3:0];
          bulk_d = 1'b1;
          st_d   = ST_BULK;
        end
        8'b0010_????: begin
          ov_d      = 1'b0;
          eng_start = 1'b1;
          eng_tx    = {hi_q, in_data[3:0]};
          bulk_d    = 1'b0;
          st_d      = ST_XFER;
        end
        8'b0011_????: hi_d = in_data[3:0];
        8'b0100_????: begin
          per_d = in_data[3:1];
          cs_d  = in_data[0];
        end
        8'b0110_0???: rc_d = in_data[2:0];
        8'b1000_????: cfg_d = bus_cfg_t'(in_data[3:0]);
        default:      od_d = NACK;
      endcase
    end

    if ((st_q == ST_XFER) && eng_done) begin
      ov_d = 1'b1;
      od_d = eng_rx;
      if (bulk_q && (left_q != 4'd0)) begin
        left_d = left_q - 4'd1;
        st_d   = ST_BULK;
      end else begin
        bulk_d = 1'b0;
        st_d   = ST_CMD;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_CMD;
      ov_q   <= 1'b0;
      od_q   <= 8'h00;
      vi_q   <= 2'd0;
      left_q <= 4'd0;
      bulk_q <= 1'b0;
      hi_q   <= 4'd0;
      cs_q   <= 1'b1;
      per_q  <= 3'd0;
      rc_q   <= 3'd0;
      cfg_q  <= BUS_CFG_RESET;
      ex_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      ov_q   <= ov_d;
      od_q   <= od_d;
      vi_q   <= vi_d;
      left_q <= left_d;
      bulk_q <= bulk_d;
      hi_q   <= hi_d;
      cs_q   <= cs_d;
      per_q  <= per_d;
      rc_q   <= rc_d;
      cfg_q  <= cfg_d;
      ex_q   <= ex_d;
    end
  end

  assign out_valid  = ov_q;
  assign out_data   = od_q;
  assign cs_level   = cs_q;
  assign pwr_en     = per_q[2];
  assign pullup_en  = per_q[1];
  assign aux_out    = per_q[0];
  assign rate_code  = rc_q;
  assign bus_cfg    = cfg_q;
  assign exit_pulse = ex_q;
endmodule

// File: rtl/spi_cmd_bridge.sv
`timescale 1ns/1ps
module spi_cmd_bridge #(
  parameter int unsigned CLK_HZ = 64_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  output logic       in_ready,
  output logic       out_valid,
  output logic [7:0] out_data,
  input  logic       out_ready,
  output logic       exit_pulse,
  output logic       spi_sclk,
  output logic       spi_mosi,
  input  logic       spi_miso,
  output logic       spi_cs,
  output logic       pin_drive,
  output logic       pwr_en,
  output logic       pullup_en,
  output logic       aux_out
);
  import spi_cmd_pkg::*;

  localparam int unsigned HW = $clog2(CLK_HZ / 60_000 + 2) + 1;

  logic [1:0]    rst_sync_q;
  logic          rst_n_sync;
  logic          eng_start, eng_busy, eng_done;
  logic [7:0]    eng_tx, eng_rx;
  logic [2:0]    rate_code;
  logic [HW-1:0] half;
  bus_cfg_t      bus_cfg;
  logic          bus_cpol;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_sync = rst_sync_q[1];

  spi_cmd_decoder u_dec (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_ready (out_ready),
    .eng_done  (eng_done),
    .eng_rx    (eng_rx),
    .eng_start (eng_start),
    .eng_tx    (eng_tx),
    .cs_level  (spi_cs),
    .pwr_en    (pwr_en),
    .pullup_en (pullup_en),
    .aux_out   (aux_out),
    .rate_code (rate_code),
    .bus_cfg   (bus_cfg),
    .exit_pulse(exit_pulse)
  );

  spi_rate_sel #(.CLK_HZ(CLK_HZ), .HW(HW)) u_rate (
    .code(rate_code),
    .half(half)
  );

  spi_shift_engine #(.HW(HW)) u_eng (
    .clk    (clk),
    .rst_n  (rst_n_sync),
    .start  (eng_start),
    .tx_byte(eng_tx),
    .cpol   (bus_cfg.cpol),
    .cke    (bus_cfg.cke),
    .smp    (bus_cfg.smp),
    .half   (half),
    .miso   (spi_miso),
    .sclk   (spi_sclk),
    .mosi   (spi_mosi),
    .busy   (eng_busy),
    .done   (eng_done),
    .rx_byte(eng_rx)
  );

  assign pin_drive = bus_cfg.drive;
  assign bus_cpol  = bus_cfg.cpol;
endmodule

// File: rtl/spi_cmd_bridge_chk.sv
`timescale 1ns/1ps
module spi_cmd_bridge_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       exit_pulse,
  input logic       sclk,
  input logic       cpol,
  input logic       cs
);
  a_r11_hold_while_shift: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !in_ready);

  a_r11_hold_while_reply: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  a_r12_reply_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  a_r9_exit_single: assert property (@(posedge clk) disable iff (!rst_n)
    exit_pulse |=> !exit_pulse);

  a_r5_sclk_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $stable(cpol)) |=> (!busy || $stable(sclk)) || $past(busy));

  a_r2_cs_steady: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> $stable(cs));
endmodule

bind spi_cmd_bridge spi_cmd_bridge_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n_sync),
  .busy      (eng_busy),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .exit_pulse(exit_pulse),
  .sclk      (spi_sclk),
  .cpol      (bus_cpol),
  .cs        (spi_cs)
);

// File: tb/spi_cmd_bridge_test.sv
`timescale 1ns/1ps
module spi_cmd_bridge_test;
  localparam int unsigned CLK_HZ = 16_000_000;

  logic       clk;
  logic       rst_n;
  logic       in_valid;
  logic [7:0] in_data;
  logic       in_ready;
  logic       out_valid;
  logic [7:0] out_data;
  logic       out_ready;
  logic       exit_pulse;
  logic       spi_sclk, spi_mosi, spi_miso, spi_cs;
  logic       pin_drive, pwr_en, pullup_en, aux_out;

  int checks = 0;
  int fails  = 0;

  spi_cmd_bridge #(.CLK_HZ(CLK_HZ)) uut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
    .exit_pulse(exit_pulse),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs(spi_cs),
    .pin_drive(pin_drive), .pwr_en(pwr_en), .pullup_en(pullup_en), .aux_out(aux_out)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // ---------------- SPI slave model ----------------
  logic       cpol_b = 1'b0;
  logic       cke_b  = 1'b1;
  logic [7:0] cap [512];
  logic [7:0] s_tx = 8'h00;
  logic [7:0] s_rx = 8'h00;
  int         s_cnt = 0;
  int         s_bit = 7;
  int         s_edge = 0;
  logic       prev_cs = 1'b1;
  logic       prev_sclk = 1'b0;

  function automatic logic [7:0] resp(input int n);
    return 8'((n * 37 + 90) & 255);
  endfunction

  initial spi_miso = 1'b0;

  always @(spi_sclk or spi_cs) begin
    if (spi_cs !== prev_cs) begin
      prev_cs   = spi_cs;
      prev_sclk = spi_sclk;
      if (spi_cs === 1'b0) begin
        s_edge = 0;
        s_bit  = 7;
        s_tx   = resp(s_cnt);
        spi_miso <= #1 s_tx[7];
      end
    end else if (spi_sclk !== prev_sclk) begin
      prev_sclk = spi_sclk;
      if (spi_cs === 1'b0) begin
        s_edge++;
        if (spi_sclk != cpol_b) begin
          if (cke_b) s_rx = {s_rx[6:0], spi_mosi};
          else begin
            if (s_edge > 1) s_bit--;
            spi_miso <= #1 s_tx[s_bit];
          end
        end else begin
          if (cke_b) begin
            if (s_bit > 0) begin
              s_bit--;
              spi_miso <= #1 s_tx[s_bit];
            end
          end else s_rx = {s_rx[6:0], spi_mosi};
        end
        if (s_edge == 16) begin
          cap[s_cnt & 511] = s_rx;
          s_cnt++;
          s_edge = 0;
          s_bit  = 7;
          s_tx   = resp(s_cnt);
          if (cke_b) spi_miso <= #1 s_tx[7];
        end
      end
    end
  end

  // ---------------- helpers ----------------
  int n_sent = 0;

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic get(output logic [7:0] b);
    out_ready = 1'b1;
    while (!out_valid) @(negedge clk);
    b = out_data;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic cmd(input logic [7:0] op, input logic [7:0] exp, input string tag);
    logic [7:0] r;
    put(op);
    get(r);
    check(r == exp, tag, r, exp);
  endtask

  // after a data byte has been accepted: check ready is held, then the returned byte
  task automatic data_done(input logic [7:0] tx, input string tag);
    logic [7:0] r;
    check(in_ready == 1'b0, "R11 ready low while shifting", in_ready, 0);
    get(r);
    check(r == resp(n_sent), tag, r, resp(n_sent));
    check(cap[n_sent & 511] == tx, {tag, " mosi"}, cap[n_sent & 511], tx);
    n_sent++;
  endtask

  task automatic bulk(input int cnt, input logic [7:0] seed, input string tag);
    cmd(8'(8'h10 + cnt - 1), 8'h01, "R3 bulk ack");
    for (int i = 0; i < cnt; i++) begin
      put(8'(seed + 8'(i * 29)));
      data_done(8'(seed + 8'(i * 29)), tag);
    end
  endtask

  task automatic set_cfg(input logic [3:0] v);
    cmd(8'h03, 8'h01, "R2 cs high ack");
    cmd(8'(8'h80 | v), 8'h01, "R5 cfg ack");
    cpol_b = v[2];
    cke_b  = v[1];
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  // ---------------- main ----------------
  initial begin
    logic [7:0] r;
    logic [5:0] snap;
    in_valid  = 1'b0;
    in_data   = 8'h00;
    out_ready = 1'b0;
    rst_n     = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check(spi_cs == 1'b1, "R1 cs", spi_cs, 1);
    check(spi_sclk == 1'b0, "R1 sclk", spi_sclk, 0);
    check({pin_drive, pwr_en, pullup_en, aux_out, exit_pulse} == 5'b0, "R1 outputs",
          {pin_drive, pwr_en, pullup_en, aux_out, exit_pulse}, 0);
    check(in_ready == 1'b1 && out_valid == 1'b0, "R1 handshake", {in_ready, out_valid}, 2);

    // R8 version string
    put(8'h01);
    get(r); check(r == 8'h53, "R8 ver0", r, 8'h53);
    get(r); check(r == 8'h50, "R8 ver1", r, 8'h50);
    get(r); check(r == 8'h49, "R8 ver2", r, 8'h49);
    get(r); check(r == 8'h31, "R8 ver3", r, 8'h31);
    repeat (2) @(negedge clk);
    check(out_valid == 1'b0, "R8 no extra byte", out_valid, 0);

    // R2 / R12 / R11: chip select with reply back-pressure
    put(8'h02);
    check(spi_cs == 1'b0, "R2 cs low", spi_cs, 0);
    check(out_valid && in_ready == 1'b0, "R11 ready low with reply", in_ready, 0);
    repeat (5) @(negedge clk);
    check(out_valid == 1'b1 && out_data == 8'h01, "R12 reply held", out_data, 1);
    get(r); check(r == 8'h01, "R2 cs low ack", r, 1);
    cmd(8'h03, 8'h01, "R2 cs high ack");
    check(spi_cs == 1'b1, "R2 cs high", spi_cs, 1);

    // R1 defaults exercised: transfer with reset rate/config (R3, R4 code 0)
    cmd(8'h02, 8'h01, "R2 cs low ack");
    bulk(1, 8'h3C, "R1 default-config byte");

    // R6 peripheral sweep
    for (int v = 0; v < 16; v++) begin
      cmd(8'(8'h40 | v), 8'h01, "R6 periph ack");
      check({pwr_en, pullup_en, aux_out, spi_cs} == 4'(v), "R6 periph outputs",
            {pwr_en, pullup_en, aux_out, spi_cs}, v);
      check(pin_drive == 1'b0, "R6 drive untouched", pin_drive, 0);
    end

    // fastest rate for the configuration sweep
    cmd(8'h67, 8'h01, "R4 rate ack");

    // R5 all 16 bus settings, each with a 2-byte bulk
    for (int v = 0; v < 16; v++) begin
      set_cfg(4'(v));
      check(pin_drive == v[3], "R5 drive flag", pin_drive, v[3]);
      check(spi_sclk == v[2], "R5 idle level", spi_sclk, v[2]);
      cmd(8'h02, 8'h01, "R2 cs low ack");
      bulk(2, 8'(v * 17 + 3), "R5 round trip");
      check(spi_sclk == v[2], "R5 idle after xfer", spi_sclk, v[2]);
    end

    // R3 maximum and minimum bulk
    set_cfg(4'b1010);
    cmd(8'h02, 8'h01, "R2 cs low ack");
    bulk(16, 8'hA1, "R3 bulk16");
    bulk(1, 8'h5E, "R3 bulk1");

    // R7 nibble staging
    cmd(8'h3A, 8'h01, "R7 hi ack");
    put(8'h25); data_done(8'hA5, "R7 nibble A5");
    put(8'h2C); data_done(8'hAC, "R7 retained hi AC");
    cmd(8'h30, 8'h01, "R7 hi ack");
    put(8'h2F); data_done(8'h0F, "R7 nibble 0F");

    // R4 rate sweep: measured SCLK half period
    for (int c = 0; c < 8; c++) begin
      int hexp;
      int cnt;
      int fr;
      case (c)
        0: fr = 30_000;     1: fr = 125_000;   2: fr = 250_000;   3: fr = 1_000_000;
        4: fr = 2_000_000;  5: fr = 2_600_000; 6: fr = 4_000_000; default: fr = 8_000_000;
      endcase
      hexp = CLK_HZ / (2 * fr);
      if (hexp < 1) hexp = 1;
      cmd(8'(8'h60 | c), 8'h01, "R4 rate ack");
      put(8'h29);
      while (spi_sclk == cpol_b) @(negedge clk);
      cnt = 0;
      do begin
        @(negedge clk);
        cnt++;
      end while (spi_sclk != cpol_b);
      check(cnt == hexp, "R4 half period", cnt, hexp);
      get(r);
      check(r == resp(n_sent), "R4 byte at rate", r, resp(n_sent));
      n_sent++;
    end

    // R10 undefined opcodes: NACK and no output change
    for (int op = 1; op < 256; op++) begin
      logic [7:0] o;
      logic defd;
      o = 8'(op);
      defd = (o <= 8'h03) || (o[7:4] inside {4'h1, 4'h2, 4'h3, 4'h4, 4'h8}) ||
             (o[7:3] == 5'b01100);
      if (!defd) begin
        snap = {pin_drive, pwr_en, pullup_en, aux_out, spi_cs, spi_sclk};
        cmd(o, 8'h00, "R10 undefined nack");
        check({pin_drive, pwr_en, pullup_en, aux_out, spi_cs, spi_sclk} == snap,
              "R10 no change", {pin_drive, pwr_en, pullup_en, aux_out, spi_cs, spi_sclk}, snap);
      end
    end

    // R9 exit
    put(8'h00);
    check(exit_pulse == 1'b1, "R9 exit raised", exit_pulse, 1);
    @(negedge clk);
    check(exit_pulse == 1'b0, "R9 exit one cycle", exit_pulse, 0);
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R9 no reply", out_valid, 0);
    put(8'h01);
    get(r); check(r == 8'h53, "R9 still decoding", r, 8'h53);
    repeat (3) begin get(r); end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule